// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves conditional branches for a 32-bit integer core. It keeps a four-bit status flag register that arithmetic instructions update as a side effect. It evaluates each branch in one of three condition styles, and it computes the PC-relative destination of the branch. It also produces the 0/1 value that a compare-to-register instruction writes into a general register, so that a later branch can test that register.

The three styles are as follows. The flags style tests the stored status flags. The register style tests one general-register operand against zero. The compare-and-branch style compares two register operands directly inside the branch. All three support equal, not-equal and signed greater-than.

The branch outcome and its target are registered. Both appear one cycle after the branch is presented. Fetch redirection, flushing and prediction belong to the surrounding pipeline.

Top module: `brc_unit`

## Requirements
- R1: While reset is asserted, and until the first operation after it, `flags`, `set_done`, `set_out`, `br_done`, `br_taken` and `br_target` are all zero.
- R2: When `fl_we` is high, `flags` takes the result of `fl_a + fl_b` (`fl_sub`=0) or `fl_a - fl_b` (`fl_sub`=1) one cycle later, with bit 3 = negative, bit 2 = zero, bit 1 = carry and bit 0 = signed overflow. For subtraction, carry means no borrow, that is `fl_a >= fl_b` unsigned. When `fl_we` is low, `flags` holds its value.
- R3: With `br_style`=0 (flags style), condition code 0 (equal) is taken when the zero flag is set. Code 1 (not-equal) is taken when the zero flag is clear. Code 2 (greater-than) is taken when the zero flag is clear and negative equals overflow. The flags used are the ones held in the cycle the branch is presented, even when `fl_we` is high in that same cycle.
- R4: One cycle after `set_valid`, `set_done` is high and `set_out` is 1 if `set_a` and `set_b` satisfy `set_cond`, and 0 otherwise. The codes are 0 = equal, 1 = not-equal, 2 = signed greater-than, 3 = never.
- R5: With `br_style`=1 (register style), code 0 is taken when `br_ra` is zero, code 1 when `br_ra` is nonzero, and code 2 when `br_ra` is signed positive.
- R6: With `br_style`=2 (compare-and-branch), code 0 is taken when `br_ra == br_rb`, code 1 when they differ, and code 2 when `br_ra > br_rb` as signed numbers.
- R7: `br_target` equals `br_pc + 4 + 4*offset` modulo 2^32, where `offset` is `br_offset` read as a signed 16-bit instruction count. This holds for positive and negative offsets.
- R8: `br_done` is high in exactly the cycle after each cycle with `br_valid` high. `br_taken` and `br_target` hold their values when `br_valid` is low.
- R9: Condition code 3 and `br_style`=3 never give a taken branch.
- R10: Compare-and-branch, register-style branches and compare-to-register operations leave `flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fl_we | input | 1 | A flag-writing arithmetic or compare instruction completes |
| fl_sub | input | 1 | 1: subtract, 0: add for the flag update |
| fl_a | input | 32 | First operand of the flag-writing operation |
| fl_b | input | 32 | Second operand of the flag-writing operation |
| set_valid | input | 1 | A compare-to-register instruction is presented |
| set_cond | input | 2 | Condition for compare-to-register |
| set_a | input | 32 | First compare-to-register operand |
| set_b | input | 32 | Second compare-to-register operand |
| br_valid | input | 1 | A conditional branch is presented |
| br_style | input | 2 | 0 flags, 1 register, 2 compare-and-branch, 3 none |
| br_cond | input | 2 | 0 equal, 1 not-equal, 2 signed greater-than, 3 never |
| br_pc | input | 32 | Address of the branch instruction |
| br_offset | input | 16 | Signed offset in instructions |
| br_ra | input | 32 | First register operand of the branch |
| br_rb | input | 32 | Second register operand (compare-and-branch) |
| flags | output | 4 | Status flags {negative, zero, carry, overflow} |
| set_done | output | 1 | Compare-to-register result valid |
| set_out | output | 32 | Compare-to-register result, 0 or 1 |
| br_done | output | 1 | Branch result valid |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Branch destination address |

## Verification
A flag-writing operation and a flags-style branch can arrive in the same cycle. In that case the branch must be judged on the flags held before the update, and the new flags become visible only one cycle later. The bench builds this collision on purpose: it first sets the zero flag, then issues a not-equal operation together with a branch-if-equal, and expects a taken branch followed by a cleared zero flag. Random traffic repeats the collision many times, and the behavioural model, which updates its own flag copy only after it has predicted the branch, judges every clock.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [1:0] {
    STY_FLAGS = 2'd0,
    STY_REG   = 2'd1,
    STY_CMP   = 2'd2,
    STY_NONE  = 2'd3
  } style_e;

  typedef enum logic [1:0] {
    CND_EQ    = 2'd0,
    CND_NE    = 2'd1,
    CND_GT    = 2'd2,
    CND_NEVER = 2'd3
  } cond_e;

  // Packed so that the 4-bit view is {n, z, c, v}
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/brc_flagcalc.sv
module brc_flagcalc
  import brc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output flags_t       flg
);

  logic [W:0]   sum_ext;
  logic [W-1:0] b_eff;
  logic [W-1:0] res;

  always_comb begin
    b_eff   = sub ? ~b : b;
    sum_ext = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    res     = sum_ext[W-1:0];
    flg.n   = res[W-1];
    flg.z   = (res == '0);
    flg.c   = sum_ext[W];
    flg.v   = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
  end

endmodule

// File: rtl/brc_condeval.sv
module brc_condeval
  import brc_pkg::*;
(
  input  flags_t     f,
  input  logic [1:0] cond,
  output logic       hit
);

  always_comb begin
    unique case (cond_e'(cond))
      CND_EQ:  hit = f.z;
      CND_NE:  hit = !f.z;
      CND_GT:  hit = !f.z && (f.n == f.v);
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] tgt
);

  localparam int EXT_W = AW - OW;

  logic [AW-1:0] off_sext;

  always_comb begin
    off_sext = {{EXT_W{off[OW-1]}}, off};
    tgt      = pc + AW'(4) + (off_sext << 2);
  end

endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fl_we,
  input  logic              fl_sub,
  input  logic [DATA_W-1:0] fl_a,
  input  logic [DATA_W-1:0] fl_b,
  input  logic              set_valid,
  input  logic [1:0]        set_cond,
  input  logic [DATA_W-1:0] set_a,
  input  logic [DATA_W-1:0] set_b,
  input  logic              br_valid,
  input  logic [1:0]        br_style,
  input  logic [1:0]        br_cond,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [OFFS_W-1:0] br_offset,
  input  logic [DATA_W-1:0] br_ra,
  input  logic [DATA_W-1:0] br_rb,
  output logic [3:0]        flags,
  output logic              set_done,
  output logic [DATA_W-1:0] set_out,
  output logic              br_done,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_target
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s0, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_q_n <= rst_s0;
    end
  end

  // datapath
  flags_t flags_q, flags_d;
  flags_t alu_flg, cmp_flg, zro_flg, set_flg, br_src_flg;
  logic   br_hit, set_hit;
  logic [1:0] br_cond_eff;
  logic [ADDR_W-1:0] tgt_calc;

  brc_flagcalc #(.W(DATA_W)) u_alu_flg (
    .a(fl_a), .b(fl_b), .sub(fl_sub), .flg(alu_flg)
  );

  brc_flagcalc #(.W(DATA_W)) u_cmp_flg (
    .a(br_ra), .b(br_rb), .sub(1'b1), .flg(cmp_flg)
  );

  brc_flagcalc #(.W(DATA_W)) u_zro_flg (
    .a(br_ra), .b({DATA_W{1'b0}}), .sub(1'b1), .flg(zro_flg)
  );

  brc_flagcalc #(.W(DATA_W)) u_set_flg (
    .a(set_a), .b(set_b), .sub(1'b1), .flg(set_flg)
  );

  always_comb begin
    br_cond_eff = br_cond;
    unique case (style_e'(br_style))
      STY_FLAGS: br_src_flg = flags_q;
      STY_REG:   br_src_flg = zro_flg;
      STY_CMP:   br_src_flg = cmp_flg;
      default: begin
        br_src_flg  = flags_q;
        br_cond_eff = CND_NEVER;
      end
    endcase
  end

  brc_condeval u_br_cond (
    .f(br_src_flg), .cond(br_cond_eff), .hit(br_hit)
  );

  brc_condeval u_set_cond (
    .f(set_flg), .cond(set_cond), .hit(set_hit)
  );

  brc_target #(.AW(ADDR_W), .OW(OFFS_W)) u_tgt (
    .pc(br_pc), .off(br_offset), .tgt(tgt_calc)
  );

  // next state
  logic              taken_q, taken_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic              bdone_q, sdone_q;
  logic [DATA_W-1:0] sout_q, sout_d;

  always_comb begin
    flags_d = fl_we     ? alu_flg  : flags_q;
    taken_d = br_valid  ? br_hit   : taken_q;
    tgt_d   = br_valid  ? tgt_calc : tgt_q;
    sout_d  = set_valid ? {{(DATA_W-1){1'b0}}, set_hit} : sout_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      flags_q <= '0;
      taken_q <= 1'b0;
      tgt_q   <= '0;
      bdone_q <= 1'b0;
      sdone_q <= 1'b0;
      sout_q  <= '0;
    end else begin
      flags_q <= flags_d;
      taken_q <= taken_d;
      tgt_q   <= tgt_d;
      bdone_q <= br_valid;
      sdone_q <= set_valid;
      sout_q  <= sout_d;
    end
  end

  assign flags     = flags_q;
  assign br_taken  = taken_q;
  assign br_target = tgt_q;
  assign br_done   = bdone_q;
  assign set_done  = sdone_q;
  assign set_out   = sout_q;

endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_we,
  input logic              set_valid,
  input logic [1:0]        br_style,
  input logic [1:0]        br_cond,
  input logic              br_valid,
  input logic [ADDR_W-1:0] br_pc,
  input logic [OFFS_W-1:0] br_offset,
  input logic [DATA_W-1:0] br_ra,
  input logic [DATA_W-1:0] br_rb,
  input logic [3:0]        flags,
  input logic              set_done,
  input logic [DATA_W-1:0] set_out,
  input logic              br_done,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target
);

  localparam int PAD = ADDR_W - OFFS_W;

  p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> br_done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !br_done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> ($stable(br_taken) && $stable(br_target)));

  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we |=> $stable(flags));

  p_cmp_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_style == 2'd2 && br_cond == 2'd0 && br_ra == br_rb) |=> br_taken);

  p_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && (br_cond == 2'd3 || br_style == 2'd3)) |=> !br_taken);

  p_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (br_target == $past(br_pc) + ADDR_W'(4)
                   + ({{PAD{$past(br_offset[OFFS_W-1])}}, $past(br_offset)} << 2)));

  p_set_binary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> (set_done && (set_out >> 1) == '0));

endmodule

bind brc_unit brc_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .fl_we(fl_we), .set_valid(set_valid),
  .br_style(br_style), .br_cond(br_cond), .br_valid(br_valid),
  .br_pc(br_pc), .br_offset(br_offset), .br_ra(br_ra), .br_rb(br_rb),
  .flags(flags), .set_done(set_done), .set_out(set_out),
  .br_done(br_done), .br_taken(br_taken), .br_target(br_target)
);

// File: tb/sim_brc_unit.sv
`timescale 1ns/1ps
module sim_brc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fl_we, fl_sub;
  logic [31:0] fl_a, fl_b;
  logic        set_valid;
  logic [1:0]  set_cond;
  logic [31:0] set_a, set_b;
  logic        br_valid;
  logic [1:0]  br_style, br_cond;
  logic [31:0] br_pc;
  logic [15:0] br_offset;
  logic [31:0] br_ra, br_rb;
  logic [3:0]  flags;
  logic        set_done;
  logic [31:0] set_out;
  logic        br_done, br_taken;
  logic [31:0] br_target;

  always #10 clk = ~clk;

  brc_unit u0 (
    .clk(clk), .rst_n(rst_n), .fl_we(fl_we), .fl_sub(fl_sub), .fl_a(fl_a), .fl_b(fl_b),
    .set_valid(set_valid), .set_cond(set_cond), .set_a(set_a), .set_b(set_b),
    .br_valid(br_valid), .br_style(br_style), .br_cond(br_cond), .br_pc(br_pc),
    .br_offset(br_offset), .br_ra(br_ra), .br_rb(br_rb), .flags(flags),
    .set_done(set_done), .set_out(set_out), .br_done(br_done), .br_taken(br_taken),
    .br_target(br_target)
  );

  int n_vec = 0;
  int n_bad = 0;

  // model state
  logic [3:0]  m_flags = 4'd0;
  logic        m_taken = 1'b0;
  logic [31:0] m_tgt   = 32'd0;
  logic [31:0] m_sout  = 32'd0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_flags(input logic [31:0] a, input logic [31:0] b, input logic sub);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'(a);
    longint ub = longint'(b);
    longint sr;
    logic [31:0] r;
    logic n, z, c, v;
    if (sub) begin
      r  = a - b;
      c  = (ua >= ub);
      sr = sa - sb;
    end else begin
      r  = a + b;
      c  = (ua + ub) >= 64'h1_0000_0000;
      sr = sa + sb;
    end
    n = r[31];
    z = (r == 32'd0);
    v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    return {n, z, c, v};
  endfunction

  function automatic logic rel(input logic [31:0] a, input logic [31:0] b, input logic [1:0] cd);
    case (cd)
      2'd0: return a == b;
      2'd1: return a != b;
      2'd2: return $signed(a) > $signed(b);
      default: return 1'b0;
    endcase
  endfunction

  task automatic idle_inputs();
    fl_we = 0; fl_sub = 0; fl_a = 0; fl_b = 0;
    set_valid = 0; set_cond = 0; set_a = 0; set_b = 0;
    br_valid = 0; br_style = 0; br_cond = 0; br_pc = 0; br_offset = 0; br_ra = 0; br_rb = 0;
  endtask

  // inputs are already driven (at a negedge); predict, clock, compare
  task automatic step();
    string tk;
    logic  e_hit;
    logic [3:0] fz;
    logic  z, n, v;
    fz = m_flags; n = fz[3]; z = fz[2]; v = fz[0];
    e_hit = 1'b0;
    tk = "R8";
    if (br_valid) begin
      if (br_cond == 2'd3 || br_style == 2'd3) begin
        e_hit = 1'b0; tk = "R9";
      end else if (br_style == 2'd0) begin
        tk = "R3";
        case (br_cond)
          2'd0: e_hit = z;
          2'd1: e_hit = !z;
          default: e_hit = !z && (n == v);
        endcase
      end else if (br_style == 2'd1) begin
        tk = "R5";
        e_hit = rel(br_ra, 32'd0, br_cond);
      end else begin
        tk = "R6";
        e_hit = rel(br_ra, br_rb, br_cond);
      end
      m_taken = e_hit;
      m_tgt   = br_pc + 32'd4 + 32'(longint'($signed(br_offset)) * 4);
    end
    if (set_valid) m_sout = {31'd0, rel(set_a, set_b, set_cond)};
    if (fl_we) m_flags = ref_flags(fl_a, fl_b, fl_sub);
    begin
      logic e_bd, e_sd;
      e_bd = br_valid; e_sd = set_valid;
      @(posedge clk);
      @(negedge clk);
      chk(br_done == e_bd, "R8 br_done", br_done, e_bd);
      chk(br_taken == m_taken, {tk, " br_taken"}, br_taken, m_taken);
      chk(br_target == m_tgt, "R7 br_target", br_target, m_tgt);
      chk(flags == m_flags, "R2/R10 flags", flags, m_flags);
      chk(set_done == e_sd, "R4 set_done", set_done, e_sd);
      chk(set_out == m_sout, "R4 set_out", set_out, m_sout);
    end
  endtask

  task automatic flag_op(input logic [31:0] a, input logic [31:0] b, input logic sub);
    idle_inputs(); fl_we = 1; fl_a = a; fl_b = b; fl_sub = sub; step();
  endtask

  task automatic branch(input logic [1:0] sty, input logic [1:0] cd, input logic [31:0] pc,
                        input logic [15:0] off, input logic [31:0] ra, input logic [31:0] rb);
    idle_inputs(); br_valid = 1; br_style = sty; br_cond = cd; br_pc = pc;
    br_offset = off; br_ra = ra; br_rb = rb; step();
  endtask

  task automatic setop(input logic [1:0] cd, input logic [31:0] a, input logic [31:0] b);
    idle_inputs(); set_valid = 1; set_cond = cd; set_a = a; set_b = b; step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(flags == 0, "R1 flags", flags, 0);
    chk(br_done == 0 && br_taken == 0, "R1 branch outs", {br_done, br_taken}, 0);
    chk(br_target == 0, "R1 br_target", br_target, 0);
    chk(set_done == 0 && set_out == 0, "R1 set outs", set_out, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step();  // idle cycle, R1 state still expected

    // R2: flag updates, add and subtract corners
    flag_op(32'd5, 32'd5, 1'b1);              // Z, C
    flag_op(32'h7fff_ffff, 32'd1, 1'b0);      // N, V
    flag_op(32'hffff_ffff, 32'd1, 1'b0);      // Z, C
    flag_op(32'd3, 32'd7, 1'b1);              // N, borrow
    flag_op(32'h8000_0000, 32'd1, 1'b1);      // V, C
    idle_inputs(); step();                    // R2 hold

    // R3: flags style
    flag_op(32'd9, 32'd9, 1'b1);
    branch(2'd0, 2'd0, 32'h1000, 16'd8, 0, 0);
    branch(2'd0, 2'd1, 32'h1000, 16'd8, 0, 0);
    flag_op(32'd10, 32'd3, 1'b1);
    branch(2'd0, 2'd2, 32'h2000, 16'hfffe, 0, 0);
    flag_op(32'hffff_fff0, 32'd4, 1'b1);
    branch(2'd0, 2'd2, 32'h2000, 16'h0001, 0, 0);
    flag_op(32'h8000_0000, 32'd1, 1'b1);      // overflow: signed min > 1 is false
    branch(2'd0, 2'd2, 32'h3000, 16'h0, 0, 0);

    // R3: collision, flag write and flags branch in the same cycle
    flag_op(32'd4, 32'd4, 1'b1);              // Z set
    idle_inputs();
    fl_we = 1; fl_sub = 1; fl_a = 32'd7; fl_b = 32'd3;
    br_valid = 1; br_style = 2'd0; br_cond = 2'd0; br_pc = 32'h4000; br_offset = 16'd2;
    step();                                   // taken on old Z; Z now clear
    branch(2'd0, 2'd0, 32'h4000, 16'd2, 0, 0);

    // R5: register style
    branch(2'd1, 2'd0, 32'h100, 16'd1, 32'd0, 0);
    branch(2'd1, 2'd0, 32'h100, 16'd1, 32'd5, 0);
    branch(2'd1, 2'd1, 32'h100, 16'd1, 32'd5, 0);
    branch(2'd1, 2'd2, 32'h100, 16'd1, 32'hffff_ffff, 0);
    branch(2'd1, 2'd2, 32'h100, 16'd1, 32'd1, 0);

    // R6: compare-and-branch, also R10 flags untouched
    branch(2'd2, 2'd0, 32'h500, 16'h8000, 32'd42, 32'd42);
    branch(2'd2, 2'd1, 32'h500, 16'h7fff, 32'd42, 32'd42);
    branch(2'd2, 2'd2, 32'h500, 16'hff80, 32'd1, 32'hffff_ffff);
    branch(2'd2, 2'd2, 32'h500, 16'd0, 32'h8000_0000, 32'd0);

    // R9: never
    branch(2'd2, 2'd3, 32'h600, 16'd1, 32'd1, 32'd1);
    branch(2'd3, 2'd0, 32'h600, 16'd1, 32'd1, 32'd1);

    // R7: wraparound target
    branch(2'd1, 2'd1, 32'hffff_fffc, 16'd0, 32'd1, 0);
    branch(2'd1, 2'd1, 32'h0000_0004, 16'hfffd, 32'd1, 0);

    // R4: compare-to-register
    setop(2'd0, 32'd8, 32'd8);
    setop(2'd1, 32'd8, 32'd8);
    setop(2'd2, 32'd1, 32'h8000_0000);
    setop(2'd3, 32'd1, 32'd1);

    // random traffic, all functions mixed
    for (int i = 0; i < 400; i++) begin
      idle_inputs();
      fl_we = $urandom_range(0, 1); fl_sub = $urandom_range(0, 1);
      fl_a = $urandom; fl_b = ($urandom_range(0, 3) == 0) ? fl_a : $urandom;
      set_valid = $urandom_range(0, 1); set_cond = 2'($urandom_range(0, 3));
      set_a = $urandom; set_b = ($urandom_range(0, 2) == 0) ? set_a : $urandom;
      br_valid = $urandom_range(0, 1); br_style = 2'($urandom_range(0, 3));
      br_cond = 2'($urandom_range(0, 3)); br_pc = {$urandom} & ~32'd3;
      br_offset = 16'($urandom);
      br_ra = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      br_rb = ($urandom_range(0, 2) == 0) ? br_ra : $urandom;
      step();
    end
    idle_inputs(); step();
    finish_run();
  end

endmodule